// File: doc/BRIEF.md
# Predicated Commit Gate with Condition Flags

This block sits in the execute stage of a pipelined processor and decides, for every instruction that reaches it, whether the instruction takes effect or becomes a no-op. Each instruction carries a 4-bit condition code. The gate tests that code against the current negative, zero, carry and overflow flags. Any instruction can be predicated this way, not only branches. A compiler can therefore turn a short if/else into a pair of conditional moves and skip the branch.

A passing instruction raises the commit strobe. It also raises the register-write strobe unless it is a compare. A failing instruction is squashed: neither strobe rises and the flags stay as they were. The gate also holds the flag register. A committed instruction that asks for a flag update loads new flags from the ALU result, carry and overflow at the next clock edge. A compare always asks for one. The next instruction is judged against these new flags. The ALU and the fetch logic are outside this block.

Top module: `cexec_squash_unit`

## Requirements
- R1: During and after reset, `out_flags` is 4'b0000. With `in_valid` low, `out_commit` and `out_regwr` are low.
- R2: When `in_valid` is low, `out_commit` and `out_regwr` stay low and `out_flags` holds its value at the next edge.
- R3: Condition 4'hE always commits a valid instruction. Condition 4'hF never commits.
- R4: Single-flag conditions, with the flag bit order `out_flags` = {N,Z,C,V}: 4'h0 passes when Z=1 and 4'h1 when Z=0. 4'h2 passes when C=1 and 4'h3 when C=0. 4'h4 passes when N=1 and 4'h5 when N=0. 4'h6 passes when V=1 and 4'h7 when V=0.
- R5: Unsigned-range conditions: 4'h8 passes when C=1 and Z=0. 4'h9 passes when C=0 or Z=1.
- R6: Signed-range conditions: 4'hA passes when N==V and 4'hB when N!=V. 4'hC passes when Z=0 and N==V. 4'hD passes when Z=1 or N!=V.
- R7: A committed instruction with `in_setflags` high loads the flags at the next clock edge. N becomes the result MSB, Z is set when the result is all zero, C becomes `in_carry` and V becomes `in_overflow`.
- R8: A squashed instruction raises neither strobe and leaves `out_flags` unchanged, even when `in_setflags` is high.
- R9: A committed compare (`in_compare` high) raises `out_commit` but not `out_regwr`. It loads the flags whether or not `in_setflags` is high.
- R10: The condition of an instruction is judged against the flags left by the instruction in the cycle before it. This holds for back-to-back instructions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is present this cycle |
| in_cond | input | 4 | Condition code of the instruction |
| in_setflags | input | 1 | Instruction requests a flag update |
| in_compare | input | 1 | Instruction is a compare (no destination write) |
| in_result | input | DATA_W | ALU result |
| in_carry | input | 1 | ALU carry out |
| in_overflow | input | 1 | ALU signed overflow |
| out_commit | output | 1 | Instruction commits this cycle |
| out_regwr | output | 1 | Destination register write enable |
| out_flags | output | 4 | Current flags {N,Z,C,V} |

## Verification
The flags can only be set through genuine ALU results. The hardest states to reach are the exact flag combinations that separate the signed and unsigned range conditions. Z=1 together with N=1 can never be produced, because a zero result has a clear MSB. Before each test instruction, the bench loads a chosen flag state with an always-pass flag-setting instruction, picking the result, carry and overflow for that state. It does this for all twelve reachable combinations. It then sweeps all sixteen conditions, with and without a flag update, so that squashed flag-setters are tried in every state.

// File: rtl/cexec_pkg.sv
package cexec_pkg;

  typedef enum logic [3:0] {
    CND_EQ = 4'h0, CND_NE = 4'h1, CND_CS = 4'h2, CND_CC = 4'h3,
    CND_MI = 4'h4, CND_PL = 4'h5, CND_VS = 4'h6, CND_VC = 4'h7,
    CND_HI = 4'h8, CND_LS = 4'h9, CND_GE = 4'hA, CND_LT = 4'hB,
    CND_GT = 4'hC, CND_LE = 4'hD, CND_AL = 4'hE, CND_NV = 4'hF
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam int unsigned FLAG_W = $bits(flags_t);

endpackage

// File: rtl/cexec_cond_eval.sv
module cexec_cond_eval
  import cexec_pkg::*;
(
  input  logic [3:0] cond,
  input  flags_t     flags,
  output logic       pass
);

  // Conditions come in complementary pairs: bits [3:1] pick a base test,
  // bit 0 inverts it. Pair 7 has base "true", so 0xE passes and 0xF fails.
  localparam int unsigned NUM_PAIRS = 8;

  logic [NUM_PAIRS-1:0] base_test;
  logic [2:0]           pair_sel;
  logic                 invert;

  always_comb begin
    base_test[0] = flags.z;
    base_test[1] = flags.c;
    base_test[2] = flags.n;
    base_test[3] = flags.v;
    base_test[4] = flags.c & ~flags.z;
    base_test[5] = ~(flags.n ^ flags.v);
    base_test[6] = ~flags.z & ~(flags.n ^ flags.v);
    base_test[7] = 1'b1;
  end

  assign pair_sel = cond[3:1];
  assign invert   = cond[0];
  assign pass     = base_test[pair_sel] ^ invert;

endmodule

// File: rtl/cexec_flag_calc.sv
module cexec_flag_calc
  import cexec_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] result,
  input  logic              carry,
  input  logic              overflow,
  output flags_t            flags_new
);

  localparam int unsigned MSB = DATA_W - 1;

  always_comb begin
    flags_new.n = result[MSB];
    flags_new.z = ~(|result);
    flags_new.c = carry;
    flags_new.v = overflow;
  end

endmodule

// File: rtl/cexec_flag_reg.sv
module cexec_flag_reg
  import cexec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_en,
  input  flags_t flags_d,
  output flags_t flags_q
);

  flags_t flags_next;

  always_comb begin
    flags_next = flags_q;
    if (load_en) begin
      flags_next = flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_next;
    end
  end

  // R8: without a load request the flags hold
  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> flags_q == $past(flags_q));

endmodule

// File: rtl/cexec_squash_unit.sv
module cexec_squash_unit
  import cexec_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_cond,
  input  logic              in_setflags,
  input  logic              in_compare,
  input  logic [DATA_W-1:0] in_result,
  input  logic              in_carry,
  input  logic              in_overflow,
  output logic              out_commit,
  output logic              out_regwr,
  output logic [3:0]        out_flags
);

  flags_t flags_cur;
  flags_t flags_alu;
  logic   cond_pass;
  logic   flag_load;

  cexec_cond_eval u_cond (
    .cond  (in_cond),
    .flags (flags_cur),
    .pass  (cond_pass)
  );

  cexec_flag_calc #(.DATA_W(DATA_W)) u_calc (
    .result    (in_result),
    .carry     (in_carry),
    .overflow  (in_overflow),
    .flags_new (flags_alu)
  );

  always_comb begin
    out_commit = in_valid & cond_pass;
    out_regwr  = out_commit & ~in_compare;
    flag_load  = out_commit & (in_setflags | in_compare);
  end

  cexec_flag_reg u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (flag_load),
    .flags_d (flags_alu),
    .flags_q (flags_cur)
  );

  assign out_flags = flags_cur;

  assert_no_commit_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !out_commit && !out_regwr);

  assert_always_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_cond == 4'hE |-> out_commit);

  assert_never_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_cond == 4'hF |-> !out_commit);

  assert_equal_follows_z_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_cond == 4'h0 |-> out_commit == out_flags[2]);

  assert_flag_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_commit && in_setflags |=>
      out_flags[2] == ($past(in_result) == '0) && out_flags[1] == $past(in_carry)
      && out_flags[0] == $past(in_overflow));

  assert_squash_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_commit |=> $stable(out_flags));

  assert_compare_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_compare |-> !out_regwr);

endmodule

// File: tb/cexec_squash_unit_test.sv
module cexec_squash_unit_test;

  localparam int unsigned DW = 8;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [3:0]    in_cond;
  logic          in_setflags;
  logic          in_compare;
  logic [DW-1:0] in_result;
  logic          in_carry;
  logic          in_overflow;
  logic          out_commit;
  logic          out_regwr;
  logic [3:0]    out_flags;

  int n_tests;
  int n_fail;
  logic [3:0] mflags; // {N,Z,C,V} model

  cexec_squash_unit #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cond(in_cond),
    .in_setflags(in_setflags), .in_compare(in_compare), .in_result(in_result),
    .in_carry(in_carry), .in_overflow(in_overflow), .out_commit(out_commit),
    .out_regwr(out_regwr), .out_flags(out_flags)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic exp_pass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'h0: return z;          4'h1: return !z;
      4'h2: return cy;         4'h3: return !cy;
      4'h4: return n;          4'h5: return !n;
      4'h6: return v;          4'h7: return !v;
      4'h8: return cy && !z;   4'h9: return !cy || z;
      4'hA: return n == v;     4'hB: return n != v;
      4'hC: return !z && n == v; 4'hD: return z || n != v;
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    if (c <= 4'h7) return "R4";
    if (c <= 4'h9) return "R5";
    if (c <= 4'hD) return "R6";
    return "R3";
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic valid, input logic [3:0] c, input logic sf,
                       input logic cmp, input logic [DW-1:0] res, input logic cy,
                       input logic ov, input string req);
    logic pass, commit;
    logic [3:0] nf;
    @(negedge clk);
    in_valid = valid; in_cond = c; in_setflags = sf; in_compare = cmp;
    in_result = res; in_carry = cy; in_overflow = ov;
    #5;
    pass   = exp_pass(c, mflags);
    commit = valid && pass;
    check(req, "commit", {7'd0, out_commit}, {7'd0, commit});
    check(cmp ? "R9" : req, "regwr", {7'd0, out_regwr}, {7'd0, commit && !cmp});
    nf = {res[DW-1], res == '0, cy, ov};
    if (commit && (sf || cmp)) mflags = nf;
    @(posedge clk); #1;
    check(commit ? "R7" : (valid ? "R8" : "R2"), "flags", {4'd0, out_flags}, {4'd0, mflags});
  endtask

  task automatic load_flags(input logic [3:0] f);
    logic [DW-1:0] r;
    r = f[2] ? '0 : (f[3] ? {1'b1, {(DW-1){1'b0}}} : {{(DW-1){1'b0}}, 1'b1});
    issue(1'b1, 4'hE, 1'b1, 1'b0, r, f[1], f[0], "R7");
  endtask

  initial begin
    n_tests = 0; n_fail = 0; mflags = 4'b0000;
    rst_n = 1'b0; in_valid = 1'b0; in_cond = 4'h0; in_setflags = 1'b0;
    in_compare = 1'b0; in_result = '0; in_carry = 1'b0; in_overflow = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset flags", {4'd0, out_flags}, 8'h00);
    check("R1", "reset commit", {7'd0, out_commit}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // Sweep reachable flag states x all conditions x flag-set request
    for (int f = 0; f < 16; f++) begin
      if (f[3] && f[2]) continue;
      for (int c = 0; c < 16; c++) begin
        for (int sf = 0; sf < 2; sf++) begin
          load_flags(4'(f));
          issue(1'b1, 4'(c), 1'(sf), 1'b0, 8'h80, 1'b1, 1'b0, req_of(4'(c)));
        end
        // compare under the same condition
        load_flags(4'(f));
        issue(1'b1, 4'(c), 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, "R9");
        // idle cycle with everything else active
        issue(1'b0, 4'(c), 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, "R2");
      end
    end

    // R10: back-to-back dependency on freshly set flags
    load_flags(4'b0000);
    issue(1'b1, 4'hE, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R10"); // compare sets Z
    issue(1'b1, 4'h0, 1'b1, 1'b0, 8'h05, 1'b0, 1'b0, "R10"); // EQ commits, clears Z
    issue(1'b1, 4'h0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, "R10"); // EQ now squashed
    check("R10", "final flags", {4'd0, out_flags}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule